// File: doc/BRIEF.md
# Open-Row SDRAM Command Sequencer

This block sits between a simple single-word read/write request port and a four-bank SDRAM. The requester supplies a bank, a row, a column and, for writes, a data word. The sequencer works out every device command itself: bank activation, column read or write, precharge, auto refresh, and the power-up sequence. The requester never sees those commands.

The sequencer keeps one open-row register and one valid flag for each bank. Each request is compared against the entry for its target bank, which gives three cases:
- **Hit:** the requested row is already open, so the column command goes out at once.
- **Empty bank:** the bank has no open row, so an activation comes first.
- **Conflict:** another row is open in that bank, so that bank alone is precharged and then the new row is activated.

Moving between banks never costs an activation if the target bank already holds the right row. A refresh closes every bank, so the next access to each bank activates again. Read data comes back with a latency that depends on which of the three cases applied, and the valid strobe follows that latency exactly.

Top module: `sdram_openpage_seq`

## Requirements
- R1: Commands on {cs_n, ras_n, cas_n, we_n} use these codes: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. A precharge drives address bit 10 high for all banks and low for a single bank.
- R2: After reset the sequencer waits T_INIT cycles and then issues, in this order, PRECHARGE with bit 10 high, AUTO REFRESH, AUTO REFRESH and LOAD MODE. The LOAD MODE address carries the CAS latency in bits 6:4 and zero in bits 3:0, which selects burst length one. req_ready stays low until this sequence ends.
- R3: A request whose row is already open in its bank produces only the column command, in the cycle after acceptance.
- R4: Open rows are tracked per bank. Returning to a bank whose recorded row matches produces no ACTIVE, whatever bank was used in between.
- R5: A request to a bank with no open row produces ACTIVE with the row on the address. The column command follows T_RCD cycles later.
- R6: A request to a bank holding a different row produces a single-bank PRECHARGE, then ACTIVE T_RP cycles later, then the column command T_RCD cycles after that.
- R7: Every REF_INTERVAL cycles a refresh takes priority over new requests. It issues PRECHARGE with bit 10 high (only if any bank is open), then AUTO REFRESH, then waits T_RFC. After a refresh, every bank counts as closed.
- R8: rd_valid pulses with rd_data T_CAS+1 cycles after the READ command. From acceptance to rd_valid takes 2+T_CAS cycles, plus T_RCD for an empty bank, plus T_RP+T_RCD for a conflict.
- R9: On a write, the data word is on sd_dq_out with sd_dq_oe high in the WRITE cycle, and wr_done pulses in the following cycle.
- R10: req_ready is low during reset and while a sequence is in progress. One request is taken per ready cycle, and ready is low in the cycle after an acceptance.
- R11: A READ or WRITE carries the column in the low address bits, with bit 10 low (no automatic precharge), and the target bank on sd_ba.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Write data |
| wr_done | output | 1 | Write issued strobe |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Row, column or mode address |
| sd_dq_out | output | DATA_W | Write data to device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Read data from device |

## Verification
The bench walks a request sequence that visits every access case. It returns to a bank after touching another one, switches rows within a bank after both a read and a write, and uses the highest row and column. A controller that forgot per-bank rows would insert an extra ACTIVE when the bank changes, which breaks the command-count and latency checks. A controller that skipped the precharge on a conflict would read from the wrong row, and the data pattern, which encodes bank, row and column, would expose it. After the automatic refresh, the bench accesses banks that had been open before. A design that kept its row table across the refresh would skip the required activation.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    S_WAIT,
    S_IPALL,
    S_IREF1,
    S_IREF2,
    S_IMRS,
    S_IDLE,
    S_PRE,
    S_ACT,
    S_COL,
    S_RPALL,
    S_RREF
  } seq_state_e;

endpackage

// File: rtl/sdram_row_table.sv
module sdram_row_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output logic              look_open,
  output logic              look_hit,
  output logic              any_open,
  input  logic              open_en,
  input  logic [BANK_W-1:0] open_bank,
  input  logic [ROW_W-1:0]  open_row,
  input  logic              close_en,
  input  logic [BANK_W-1:0] close_bank,
  input  logic              close_all
);

  localparam int BANKS = 1 << BANK_W;

  logic [BANKS-1:0] valid;
  logic [ROW_W-1:0] rows [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             v_q;
    logic [ROW_W-1:0] r_q;
    logic             clr_hit;
    logic             set_hit;

    assign clr_hit = close_all || (close_en && (close_bank == BANK_W'(b)));
    assign set_hit = open_en && (open_bank == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        r_q <= '0;
      end else if (clr_hit) begin
        v_q <= 1'b0;
      end else if (set_hit) begin
        v_q <= 1'b1;
        r_q <= open_row;
      end
    end

    assign valid[b] = v_q;
    assign rows[b]  = r_q;
  end

  assign look_open = valid[look_bank];
  assign look_hit  = look_open && (rows[look_bank] == look_row);
  assign any_open  = |valid;

  // R7: the sequencer never opens a row while closing all banks
  p_no_open_on_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    close_all |-> !open_en);

  // R5: after an open the addressed bank reads back as open
  p_open_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (open_en && !close_all && !close_en && look_bank == open_bank) |=> look_open);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic due
);

  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      due <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      due <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      if (ack) due <= 1'b0;
    end
  end

  // R7: a pending refresh stays pending until it is served
  p_due_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !ack) |=> due);

endmodule

// File: rtl/sdram_openpage_seq.sv
module sdram_openpage_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 16,
  parameter int T_RP         = 2,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_WR         = 2,
  parameter int T_RFC        = 6,
  parameter int T_MRD        = 2,
  parameter int T_INIT       = 10000,
  parameter int REF_INTERVAL = 780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              wr_done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);

  localparam int CNT_W = $clog2(T_INIT + T_RFC + T_RP + T_RCD + T_WR + T_MRD + 2);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(T_CAS << 4);
  localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1 << 10);

  seq_state_e state, state_n, ret, ret_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  logic              lat_wr;
  logic [BANK_W-1:0] lat_bank;
  logic [ROW_W-1:0]  lat_row;
  logic [COL_W-1:0]  lat_col;
  logic [DATA_W-1:0] lat_wdata;

  sd_cmd_e cmd;
  logic    accept;
  logic    ref_due, ref_ack;
  logic    rd_busy;
  logic    issue_rd;
  logic [T_CAS-1:0] rd_pipe, rd_pipe_n;

  logic              look_open, look_hit, any_open;
  logic [BANK_W-1:0] look_bank;
  logic [ROW_W-1:0]  look_row;
  logic              open_en, close_en, close_all;

  assign look_bank = (state == S_IDLE) ? req_bank : lat_bank;
  assign look_row  = (state == S_IDLE) ? req_row  : lat_row;

  sdram_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_bank  (look_bank),
    .look_row   (look_row),
    .look_open  (look_open),
    .look_hit   (look_hit),
    .any_open   (any_open),
    .open_en    (open_en),
    .open_bank  (lat_bank),
    .open_row   (lat_row),
    .close_en   (close_en),
    .close_bank (lat_bank),
    .close_all  (close_all)
  );

  sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (ref_ack),
    .due   (ref_due)
  );

  assign rd_busy   = |rd_pipe;
  assign req_ready = (state == S_IDLE) && !rd_busy && !ref_due;

  // next-state and command decode
  always_comb begin
    state_n   = state;
    ret_n     = ret;
    cnt_n     = cnt;
    cmd       = CMD_NOP;
    sd_ba     = '0;
    sd_addr   = '0;
    open_en   = 1'b0;
    close_en  = 1'b0;
    close_all = 1'b0;
    ref_ack   = 1'b0;
    accept    = 1'b0;
    unique case (state)
      S_WAIT: begin
        if (cnt <= CNT_W'(1)) state_n = ret;
        else                  cnt_n   = cnt - 1'b1;
      end
      S_IPALL: begin
        cmd = CMD_PRE; sd_addr = ALL_BANKS; close_all = 1'b1;
        state_n = S_WAIT; cnt_n = CNT_W'(T_RP - 1); ret_n = S_IREF1;
      end
      S_IREF1: begin
        cmd = CMD_REF;
        state_n = S_WAIT; cnt_n = CNT_W'(T_RFC - 1); ret_n = S_IREF2;
      end
      S_IREF2: begin
        cmd = CMD_REF;
        state_n = S_WAIT; cnt_n = CNT_W'(T_RFC - 1); ret_n = S_IMRS;
      end
      S_IMRS: begin
        cmd = CMD_MRS; sd_addr = MODE_WORD;
        state_n = S_WAIT; cnt_n = CNT_W'(T_MRD - 1); ret_n = S_IDLE;
      end
      S_IDLE: begin
        if (!rd_busy) begin
          if (ref_due) begin
            state_n = any_open ? S_RPALL : S_RREF;
          end else if (req_valid) begin
            accept = 1'b1;
            if (look_hit)       state_n = S_COL;
            else if (look_open) state_n = S_PRE;
            else                state_n = S_ACT;
          end
        end
      end
      S_PRE: begin
        cmd = CMD_PRE; sd_ba = lat_bank; close_en = 1'b1;
        state_n = S_WAIT; cnt_n = CNT_W'(T_RP - 1); ret_n = S_ACT;
      end
      S_ACT: begin
        cmd = CMD_ACT; sd_ba = lat_bank; sd_addr = lat_row; open_en = 1'b1;
        state_n = S_WAIT; cnt_n = CNT_W'(T_RCD - 1); ret_n = S_COL;
      end
      S_COL: begin
        cmd = lat_wr ? CMD_WR : CMD_RD;
        sd_ba = lat_bank; sd_addr = ROW_W'(lat_col);
        if (lat_wr) begin
          state_n = S_WAIT; cnt_n = CNT_W'(T_WR - 1); ret_n = S_IDLE;
        end else begin
          state_n = S_IDLE;
        end
      end
      S_RPALL: begin
        cmd = CMD_PRE; sd_addr = ALL_BANKS; close_all = 1'b1;
        state_n = S_WAIT; cnt_n = CNT_W'(T_RP - 1); ret_n = S_RREF;
      end
      S_RREF: begin
        cmd = CMD_REF; ref_ack = 1'b1; close_all = 1'b1;
        state_n = S_WAIT; cnt_n = CNT_W'(T_RFC - 1); ret_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_dq_out = lat_wdata;
  assign sd_dq_oe  = (cmd == CMD_WR);
  assign issue_rd  = (state == S_COL) && !lat_wr;

  if (T_CAS == 1) begin : g_lat1
    assign rd_pipe_n = issue_rd;
  end else begin : g_latn
    assign rd_pipe_n = {rd_pipe[T_CAS-2:0], issue_rd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_WAIT;
      ret      <= S_IPALL;
      cnt      <= CNT_W'(T_INIT);
      rd_pipe  <= '0;
      rd_valid <= 1'b0;
      wr_done  <= 1'b0;
    end else begin
      state    <= state_n;
      ret      <= ret_n;
      cnt      <= cnt_n;
      rd_pipe  <= rd_pipe_n;
      rd_valid <= rd_pipe[T_CAS-1];
      wr_done  <= (state == S_COL) && lat_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      lat_wr    <= req_write;
      lat_bank  <= req_bank;
      lat_row   <= req_row;
      lat_col   <= req_col;
      lat_wdata <= req_wdata;
    end
    if (rd_pipe[T_CAS-1]) rd_data <= sd_dq_in;
  end

  p_one_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_col_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> look_hit);

  p_act_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> !look_open);

  p_pre_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && !sd_addr[10]) |-> (look_open && !look_hit));

  p_ref_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> !any_open);

  p_wrdone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $past(cmd == CMD_WR));

  p_rdvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_busy));

endmodule

// File: tb/sdram_openpage_seq_bench.sv
`timescale 1ns/1ps
module sdram_openpage_seq_bench;

  localparam int TRP = 2, TRCD = 2, TCAS = 2, TWR = 2, TRFC = 6;
  localparam int TINIT = 40, TREF = 1200;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;

  // wr[41] bank[40:39] row[38:27] col[26:18] path[17:16] wdata[15:0]
  // path: 0 hit, 1 empty bank, 2 conflict
  localparam logic [41:0] VEC [0:11] = '{
    {1'b0, 2'd0, 12'd5,    9'd3,   2'd1, 16'h0000},
    {1'b0, 2'd0, 12'd5,    9'd4,   2'd0, 16'h0000},
    {1'b1, 2'd1, 12'd7,    9'd1,   2'd1, 16'hA5C3},
    {1'b0, 2'd0, 12'd5,    9'd9,   2'd0, 16'h0000},
    {1'b1, 2'd1, 12'd7,    9'd2,   2'd0, 16'h1234},
    {1'b0, 2'd1, 12'd8,    9'd0,   2'd2, 16'h0000},
    {1'b1, 2'd0, 12'd6,    9'd5,   2'd2, 16'hFFFF},
    {1'b0, 2'd2, 12'd0,    9'd0,   2'd1, 16'h0000},
    {1'b0, 2'd3, 12'd4095, 9'd511, 2'd1, 16'h0000},
    {1'b0, 2'd2, 12'd0,    9'd7,   2'd0, 16'h0000},
    {1'b1, 2'd3, 12'd4095, 9'd1,   2'd0, 16'h0001},
    {1'b0, 2'd1, 12'd8,    9'd1,   2'd0, 16'h0000}
  };

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [1:0]  req_bank;
  logic [11:0] req_row;
  logic [8:0]  req_col;
  logic [15:0] req_wdata;
  logic wr_done, rd_valid;
  logic [15:0] rd_data;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [15:0] sd_dq_out, sd_dq_in;
  logic sd_dq_oe;

  sdram_openpage_seq #(
    .T_RP(TRP), .T_RCD(TRCD), .T_CAS(TCAS), .T_WR(TWR), .T_RFC(TRFC),
    .T_INIT(TINIT), .REF_INTERVAL(TREF)
  ) u_sdram_openpage_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .wr_done(wr_done), .rd_valid(rd_valid),
    .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // command log and device model
  logic [3:0]  log_cmd  [0:15];
  logic [1:0]  log_ba   [0:15];
  logic [11:0] log_addr [0:15];
  logic [15:0] log_dq   [0:15];
  int          log_n = 0;
  logic [11:0] mdl_row  [0:3];
  logic [15:0] slot     [0:7];

  function automatic logic [15:0] pat(input logic [1:0] b, input logic [11:0] r,
                                      input logic [8:0] c);
    return {b, r[4:0], c};
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) slot[i] = '0;
    for (int i = 0; i < 4; i++) mdl_row[i] = '0;
    sd_dq_in = '0;
  end

  always @(negedge clk) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    for (int i = 0; i < 7; i++) slot[i] = slot[i+1];
    slot[7] = '0;
    if (rst_n && c != C_NOP) begin
      if (log_n < 16) begin
        log_cmd[log_n]  = c;
        log_ba[log_n]   = sd_ba;
        log_addr[log_n] = sd_addr;
        log_dq[log_n]   = sd_dq_oe ? sd_dq_out : 16'hxxxx;
        log_n++;
      end
      if (c == C_ACT) mdl_row[sd_ba] = sd_addr;
      if (c == C_RD)  slot[TCAS] = pat(sd_ba, mdl_row[sd_ba], sd_addr[8:0]);
    end
    sd_dq_in = slot[0];
  end

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic run_req(input logic wr, input logic [1:0] b, input logic [11:0] r,
                         input logic [8:0] c, input logic [15:0] d,
                         input int path, input string seq_tag);
    int c0, lat, exp_lat, exp_n, k;
    bit done;
    for (int i = 0; i < 300 && !req_ready; i++) step();
    log_n = 0;
    c0 = cyc;
    req_valid = 1'b1; req_write = wr; req_bank = b; req_row = r;
    req_col = c; req_wdata = d;
    step();
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 ready after accept", req_ready, 0);
    done = 0;
    lat = 0;
    for (int i = 0; i < 60 && !done; i++) begin
      if (wr ? wr_done : rd_valid) begin
        done = 1;
        lat = cyc - c0;
        if (!wr) chk(rd_data == pat(b, r, c), "R8 read data", rd_data, pat(b, r, c));
      end else begin
        step();
      end
    end
    exp_lat = (wr ? 2 : 2 + TCAS) + (path == 1 ? TRCD : 0) + (path == 2 ? TRP + TRCD : 0);
    chk(done && lat == exp_lat, wr ? "R9 write done cycle" : "R8 read latency",
        lat, exp_lat);
    exp_n = path + 1;
    chk(log_n == exp_n, seq_tag, log_n, exp_n);
    k = 0;
    if (path == 2) begin
      chk(log_cmd[0] == C_PRE && log_ba[0] == b && !log_addr[0][10],
          "R6 single bank precharge", {log_cmd[0], log_ba[0], log_addr[0]}, {C_PRE, b, 12'h0});
      k = 1;
    end
    if (path >= 1) begin
      chk(log_cmd[k] == C_ACT && log_ba[k] == b && log_addr[k] == r,
          "R5 activate", {log_cmd[k], log_ba[k], log_addr[k]}, {C_ACT, b, r});
      k++;
    end
    chk(log_cmd[k] == (wr ? C_WR : C_RD) && log_ba[k] == b &&
        log_addr[k] == {3'b000, c} && !log_addr[k][10],
        "R11 column command", {log_cmd[k], log_ba[k], log_addr[k]},
        {(wr ? C_WR : C_RD), b, 3'b000, c});
    if (wr) chk(log_dq[k] === d, "R9 write data", log_dq[k], d);
  endtask

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_bank = '0; req_row = '0;
    req_col = '0; req_wdata = '0;
    rst_n = 1'b0;
    step(); step(); step();
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 NOP in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(req_ready == 1'b0, "R10 ready low in reset", req_ready, 0);
    rst_n = 1'b1;
    log_n = 0;
    for (int i = 0; i < 400 && !req_ready; i++) step();
    chk(log_n == 4, "R2 init command count", log_n, 4);
    chk(log_cmd[0] == C_PRE && log_addr[0][10], "R1 precharge all code",
        {log_cmd[0], log_addr[0]}, {C_PRE, 12'h400});
    chk(log_cmd[1] == C_REF && log_cmd[2] == C_REF, "R2 two refreshes",
        {log_cmd[1], log_cmd[2]}, {C_REF, C_REF});
    chk(log_cmd[3] == C_MRS && log_addr[3] == 12'(TCAS << 4), "R2 mode word",
        {log_cmd[3], log_addr[3]}, {C_MRS, 12'(TCAS << 4)});

    for (int v = 0; v < 12; v++) begin
      logic [41:0] e;
      int p;
      e = VEC[v];
      p = int'(e[17:16]);
      run_req(e[41], e[40:39], e[38:27], e[26:18], e[15:0], p,
              (v == 3) ? "R4 bank return no activate" :
              (p == 0) ? "R3 hit command count" :
              (p == 1) ? "R5 empty command count" : "R6 conflict command count");
    end

    // wait for the periodic refresh
    for (int i = 0; i < 8 && !req_ready; i++) step();
    log_n = 0;
    begin
      bit seen;
      seen = 0;
      for (int i = 0; i < 2000 && !seen; i++) begin
        step();
        if (log_n >= 2) seen = 1;
        if (log_n == 1) chk(req_ready == 1'b0, "R7 ready low in refresh", req_ready, 0);
      end
      chk(seen, "R7 refresh issued", seen, 1);
      chk(log_cmd[0] == C_PRE && log_addr[0][10] && log_cmd[1] == C_REF,
          "R7 precharge all then refresh", {log_cmd[0], log_cmd[1]}, {C_PRE, C_REF});
    end
    run_req(1'b0, 2'd1, 12'd8, 9'd2, 16'h0, 1, "R7 bank closed after refresh");
    run_req(1'b1, 2'd0, 12'd6, 9'd6, 16'h5A5A, 1, "R7 second bank closed after refresh");
    run_req(1'b0, 2'd0, 12'd6, 9'd6, 16'h0, 0, "R3 hit after reopen");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule